// File: doc/BRIEF.md
# Phase-Staggered Triangle-Carrier Gate Generator

This block drives the gates of a stack of series-connected single-phase H-bridges. Each bridge gets three-level sine-triangle modulation. A shared signed modulation sample is first divided by a per-bridge normalised dc-link voltage. The quotient is then held once per carrier half-period and compared against that bridge's triangular carrier. One leg of the bridge compares the held value with the carrier. The other leg compares its negation with the same carrier. Each bridge owns its own carrier. The carriers of successive bridges start at staggered points of the triangle, so the switching edges of the stacked output interleave and the stack yields 2N+1 voltage levels.

A two-state controller sequences the block. In `ST_IDLE` (parked) all gates are low. The carriers sit at their phase offsets, the carrier period is captured from the input, and the held references follow the input. The transition *launch* (`ST_IDLE` to `ST_RUN`) fires on the first rising edge with the enable high. In `ST_RUN` the carriers step once per clock. The transition *halt* (`ST_RUN` to `ST_IDLE`) fires on any edge with the enable low. Gate outputs are also masked combinationally by the enable. Dead-time, reference synthesis and closed-loop control sit outside the block.

Top module: `pscpwm_gen`

## Requirements
- R1: After reset, and in every cycle in which `en_i` is low, every bit of `gate_o` is 0.
- R2: Bridge k owns `gate_o[4k+3:4k]`. Bit 0 drives the upper switch of leg A and bit 2 the lower switch of leg A. Bit 1 drives the upper switch of leg B and bit 3 the lower switch of leg B. While enabled, bit 2 is the inverse of bit 0 and bit 3 is the inverse of bit 1. The module therefore outputs +Vdc on bits {0,3}, -Vdc on bits {1,2}, and zero on bits {0,1} or {2,3}.
- R3: In `ST_RUN` each carrier moves by exactly one count per clock, stays within 0..P where P is the captured period, and reverses direction on reaching P and on reaching 0. One triangle therefore lasts 2P clocks.
- R4: On the clock that leaves `ST_IDLE`, bridge k (0-based) starts at triangle position floor(2·P·k/N). A position t ≤ P gives a carrier value of t, rising (falling when t = P). A position t > P gives a carrier value of 2P−t, falling.
- R5: Given held value h and carrier c, leg A is high exactly when P + h > 2c, and leg B is high exactly when P − h > 2c. Both legs of a bridge use that bridge's carrier.
- R6: The scaled reference for bridge k is trunc((ref·256) / s_k), truncated toward zero. Here s_k is the unsigned 8-fractional-bit scale in `scale_i[SW·k +: SW]`, and a scale of 0 is treated as 1.
- R7: The scaled reference is clipped to the range −P..+P before it is held.
- R8: In `ST_RUN` a bridge's held value changes only on a clock edge at which that bridge's carrier is at 0 or at P. It then takes the clipped scaled reference present at that edge. In `ST_IDLE` it takes that value on every edge.
- R9: The period is captured only on edges at which the block is not running. Changes to `period_i` while running have no effect on the carriers or the gates.
- R10: After `en_i` rises, gates follow R5 from the first rising edge, with every carrier at its R4 offset. After a fall and a later rise, the carriers start again from their offsets.
- R11: A `period_i` value below 2 is captured as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces all gates off |
| period_i | input | CW | Carrier peak count P (half of the triangle length) |
| ref_i | input | RW | Signed modulation sample, common to all bridges |
| scale_i | input | N_MOD·SW | Per-bridge normalised dc-link voltage, 8 fractional bits |
| gate_o | output | 4·N_MOD | Four gate drives per bridge, see R2 |

## Verification
The hardest situation to reach is a change in the reference or the period that lands exactly on the edge where one carrier reverses while the other carriers are mid-ramp. Only there do the sample-and-hold timing and the per-bridge staggering separate a correct design from an off-by-one one. The stimulus uses short periods, so the reversal points come every few clocks, and it changes the reference on every clock. It also toggles the enable and rewrites the period at random points, mid-run as well as while parked, so that reversal edges, relaunches and ignored period writes are hit many times.

// File: rtl/pscpwm_pkg.sv
package pscpwm_pkg;

    localparam int SCALE_FRAC = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } ramp_dir_e;

    // Divide the reference by the scale (zero treated as one) and clip to +/-lim.
    function automatic int scale_and_clip(input int ref_v, input int scale_v, input int lim);
        int den;
        int quo;
        den = (scale_v == 0) ? 1 : scale_v;
        quo = (ref_v * (1 << SCALE_FRAC)) / den;
        if (quo > lim) begin
            quo = lim;
        end else if (quo < -lim) begin
            quo = -lim;
        end
        return quo;
    endfunction

endpackage

// File: rtl/pscpwm_carrier.sv
module pscpwm_carrier
    import pscpwm_pkg::*;
#(
    parameter int CW    = 10,
    parameter int N_MOD = 3,
    parameter int IDX   = 0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic          adv_i,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] per_q_i,
    output logic [CW-1:0] cnt_o,
    output logic          peak_o
);

    logic [CW-1:0] cnt_q;
    ramp_dir_e     dir_q;
    logic [CW-1:0] off_cnt;
    ramp_dir_e     off_dir;
    int            pe;
    int            t_off;

    // Starting point inside the triangle for this bridge.
    always_comb begin
        pe    = int'(period_i);
        t_off = (2 * pe * IDX) / N_MOD;
        if (t_off < pe) begin
            off_cnt = CW'(t_off);
            off_dir = DIR_UP;
        end else begin
            off_cnt = CW'(2 * pe - t_off);
            off_dir = DIR_DOWN;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (load_i) begin
            cnt_q <= off_cnt;
            dir_q <= off_dir;
        end else if (adv_i) begin
            unique case (dir_q)
                DIR_UP: begin
                    if (cnt_q + 1'b1 == per_q_i) begin
                        dir_q <= DIR_DOWN;
                    end
                    cnt_q <= cnt_q + 1'b1;
                end
                DIR_DOWN: begin
                    if (cnt_q == CW'(1)) begin
                        dir_q <= DIR_UP;
                    end
                    cnt_q <= cnt_q - 1'b1;
                end
                default: begin
                    cnt_q <= cnt_q;
                end
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign peak_o = (cnt_q == '0) || (cnt_q == per_q_i);

    // R3
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |=> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1)));

    // R3
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |-> (cnt_q <= per_q_i));

endmodule

// File: rtl/pscpwm_bridge.sv
module pscpwm_bridge
    import pscpwm_pkg::*;
#(
    parameter int CW = 10,
    parameter int RW = 12,
    parameter int SW = 10
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 track_i,
    input  logic                 adv_i,
    input  logic                 act_i,
    input  logic                 peak_i,
    input  logic [CW-1:0]        cnt_i,
    input  logic [CW-1:0]        per_q_i,
    input  logic [CW-1:0]        per_in_i,
    input  logic signed [RW-1:0] ref_i,
    input  logic [SW-1:0]        scale_i,
    output logic [3:0]           gate_o
);

    localparam int HW = CW + 1;

    logic signed [HW-1:0] hold_q;
    logic signed [HW-1:0] clip_run;
    logic signed [HW-1:0] clip_idle;
    logic                 leg_a;
    logic                 leg_b;

    always_comb begin
        clip_run  = HW'(scale_and_clip(int'(ref_i), int'(scale_i), int'(per_q_i)));
        clip_idle = HW'(scale_and_clip(int'(ref_i), int'(scale_i), int'(per_in_i)));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q <= '0;
        end else if (track_i) begin
            hold_q <= clip_idle;
        end else if (adv_i && peak_i) begin
            hold_q <= clip_run;
        end
    end

    // Opposed references against one shared carrier.
    always_comb begin
        leg_a = (int'(per_q_i) + int'(hold_q)) > 2 * int'(cnt_i);
        leg_b = (int'(per_q_i) - int'(hold_q)) > 2 * int'(cnt_i);
        if (act_i) begin
            gate_o = {~leg_b, ~leg_a, leg_b, leg_a};
        end else begin
            gate_o = 4'b0000;
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !peak_i) |=> $stable(hold_q));

    // R7
    hold_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !track_i |-> ((int'(hold_q) <= int'(per_q_i)) && (int'(hold_q) >= -int'(per_q_i))));

endmodule

// File: rtl/pscpwm_gen.sv
module pscpwm_gen
    import pscpwm_pkg::*;
#(
    parameter int N_MOD = 3,
    parameter int CW    = 10,
    parameter int RW    = 12,
    parameter int SW    = 10
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  en_i,
    input  logic [CW-1:0]         period_i,
    input  logic signed [RW-1:0]  ref_i,
    input  logic [N_MOD*SW-1:0]   scale_i,
    output logic [4*N_MOD-1:0]    gate_o
);

    localparam int GW = 4 * N_MOD;

    run_state_e    st_q;
    run_state_e    st_d;
    logic          run;
    logic [CW-1:0] per_eff;
    logic [CW-1:0] per_q;
    logic [GW-1:0] gate_w;

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions: launch (idle to run), halt (run to idle).
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = en_i ? ST_RUN : ST_IDLE;
            ST_RUN:  st_d = en_i ? ST_RUN : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign run     = (st_q == ST_RUN) && en_i;
    assign per_eff = (period_i < CW'(2)) ? CW'(2) : period_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            per_q <= '0;
        end else if (!run) begin
            per_q <= per_eff;
        end
    end

    for (genvar k = 0; k < N_MOD; k++) begin : g_mod
        logic [CW-1:0] cnt;
        logic          peak;

        pscpwm_carrier #(
            .CW    (CW),
            .N_MOD (N_MOD),
            .IDX   (k)
        ) u_car (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .load_i   (!run),
            .adv_i    (run),
            .period_i (per_eff),
            .per_q_i  (per_q),
            .cnt_o    (cnt),
            .peak_o   (peak)
        );

        pscpwm_bridge #(
            .CW (CW),
            .RW (RW),
            .SW (SW)
        ) u_brg (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .track_i  (!run),
            .adv_i    (run),
            .act_i    (run),
            .peak_i   (peak),
            .cnt_i    (cnt),
            .per_q_i  (per_q),
            .per_in_i (per_eff),
            .ref_i    (ref_i),
            .scale_i  (scale_i[k*SW +: SW]),
            .gate_o   (gate_w[4*k +: 4])
        );
    end

    // Output process.
    always_comb begin
        unique case (st_q)
            ST_RUN:  gate_o = gate_w;
            ST_IDLE: gate_o = '0;
            default: gate_o = '0;
        endcase
    end

    // R1
    gates_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> (gate_o == '0));

    // R9
    period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && $past(run)) |-> $stable(per_q));

endmodule

// File: tb/sim_pscpwm_gen.sv
module sim_pscpwm_gen;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 3;
    localparam int CW = 10;
    localparam int RW = 12;
    localparam int SW = 10;

    logic                 clk;
    logic                 rst_n;
    logic                 en;
    logic [CW-1:0]        period;
    logic signed [RW-1:0] refv;
    logic [N*SW-1:0]      scale;
    logic [4*N-1:0]       gate;

    int n_vec;
    int n_bad;
    bit done;

    int mt [N];
    int mh [N];
    int mpq;
    bit mst;

    pscpwm_gen #(.N_MOD(N), .CW(CW), .RW(RW), .SW(SW)) u0 (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .en_i     (en),
        .period_i (period),
        .ref_i    (refv),
        .scale_i  (scale),
        .gate_o   (gate)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int eff_per(int p);
        return (p < 2) ? 2 : p;
    endfunction

    function automatic int clip(int r, int s, int lim);
        int d;
        int q;
        d = (s == 0) ? 1 : s;
        q = (r * 256) / d;
        if (q > lim) q = lim;
        if (q < -lim) q = -lim;
        return q;
    endfunction

    function automatic int tri_val(int t, int p);
        return (t <= p) ? t : 2 * p - t;
    endfunction

    function automatic logic [4*N-1:0] expect_gates();
        logic [4*N-1:0] v;
        v = '0;
        if (mst && en) begin
            for (int k = 0; k < N; k++) begin
                int  c;
                logic a;
                logic b;
                c = tri_val(mt[k], mpq);
                a = (mpq + mh[k]) > 2 * c;
                b = (mpq - mh[k]) > 2 * c;
                v[4*k +: 4] = {~b, ~a, b, a};
            end
        end
        return v;
    endfunction

    task automatic model_advance();
        int pin;
        pin = eff_per(int'(period));
        if (mst && en) begin
            for (int k = 0; k < N; k++) begin
                int c;
                c = tri_val(mt[k], mpq);
                if (c == 0 || c == mpq) begin
                    mh[k] = clip(int'(refv), int'(scale[k*SW +: SW]), mpq);
                end
                mt[k] = (mt[k] + 1) % (2 * mpq);
            end
        end else begin
            mpq = pin;
            for (int k = 0; k < N; k++) begin
                mt[k] = (2 * pin * k) / N;
                mh[k] = clip(int'(refv), int'(scale[k*SW +: SW]), pin);
            end
        end
        mst = en;
    endtask

    task automatic check(string tag);
        logic [4*N-1:0] e;
        e = expect_gates();
        n_vec++;
        if (gate !== e) begin
            n_bad++;
            $display("FAIL %s: gate_o=%h expected %h at %0t", tag, gate, e, $time);
        end
        if (mst && en) begin
            for (int k = 0; k < N; k++) begin
                n_vec++;
                if (gate[4*k+2] !== ~gate[4*k] || gate[4*k+3] !== ~gate[4*k+1]) begin
                    n_bad++;
                    $display("FAIL R2: bridge %0d gates=%b expected complementary pairs", k, gate[4*k +: 4]);
                end
            end
        end
    endtask

    task automatic step(string tag);
        model_advance();
        @(negedge clk);
        check(tag);
    endtask

    task automatic set_scales(int a, int b, int c);
        scale = {SW'(c), SW'(b), SW'(a)};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        n_vec = 0;
        n_bad = 0;
        done  = 1'b0;
        mst = 1'b0;
        mpq = 0;
        for (int k = 0; k < N; k++) begin
            mt[k] = 0;
            mh[k] = 0;
        end
        rst_n = 1'b0;
        en = 1'b0;
        period = CW'(8);
        refv = '0;
        set_scales(256, 256, 256);
        repeat (3) @(negedge clk);
        // R1: reset state
        n_vec++;
        if (gate !== '0) begin
            n_bad++;
            $display("FAIL R1: gate_o=%h expected 0 in reset", gate);
        end
        rst_n = 1'b1;

        // R1: disabled with changing inputs
        for (int i = 0; i < 10; i++) begin
            refv = RW'($urandom_range(4095));
            step("R1");
        end

        // R10 / R4: launch, zero reference, period 6
        period = CW'(6);
        refv = '0;
        step("R1");
        en = 1'b1;
        step("R10");
        for (int i = 0; i < 30; i++) step("R3");

        // R5: fixed positive reference with equal scales
        refv = RW'(3);
        for (int i = 0; i < 30; i++) step("R5");

        // R6: distinct scales per bridge
        en = 1'b0;
        step("R1");
        period = CW'(20);
        set_scales(512, 256, 128);
        refv = RW'(7);
        en = 1'b1;
        step("R4");
        for (int i = 0; i < 80; i++) step("R6");

        // R6: zero scale treated as one
        set_scales(0, 300, 1000);
        refv = -RW'(1);
        for (int i = 0; i < 60; i++) step("R6");

        // R7: saturating references, both signs
        set_scales(1, 1, 1);
        refv = RW'(2047);
        for (int i = 0; i < 45; i++) step("R7");
        refv = -RW'(2048);
        for (int i = 0; i < 45; i++) step("R7");

        // R9: period rewritten while running is ignored
        set_scales(256, 256, 256);
        refv = RW'(5);
        period = CW'(3);
        for (int i = 0; i < 60; i++) step("R9");

        // R11: period below 2 becomes 2
        en = 1'b0;
        period = CW'(0);
        step("R1");
        en = 1'b1;
        for (int i = 0; i < 20; i++) step("R11");
        en = 1'b0;
        period = CW'(1);
        step("R1");
        en = 1'b1;
        for (int i = 0; i < 20; i++) step("R11");

        // R8: reference changes every clock
        en = 1'b0;
        period = CW'(5);
        step("R1");
        en = 1'b1;
        for (int i = 0; i < 200; i++) begin
            refv = RW'($urandom_range(4095));
            step("R8");
        end

        // Random mix of all behaviours
        for (int i = 0; i < 6000; i++) begin
            refv = RW'($urandom_range(4095));
            if ($urandom_range(49) == 0) begin
                set_scales($urandom_range(1023), $urandom_range(600), $urandom_range(400));
            end
            if ($urandom_range(99) == 0) begin
                en = ~en;
            end
            if ($urandom_range(79) == 0) begin
                period = ($urandom_range(9) == 0) ? CW'($urandom_range(1)) : CW'($urandom_range(40));
            end
            step(en ? "R8" : "R10");
        end

        finish_run();
    end

endmodule